// File: doc/BRIEF.md
# Vector Gather Address Generator

This block turns one 32-bit address-compute instruction word and two source vectors into a vector of memory addresses. The first vector holds base addresses and the second holds offsets. Each lane's address is its base plus its offset. The offset may first be sign-extended or zero-extended from its low 32 bits, and it is then shifted left by 0 to 3 bits. The sum wraps within the lane width. Every lane is written; there is no predication.

The instruction picks one of three lane layouts. In the packed layout, 32-bit or 64-bit lanes use the whole offset element. In the two unpacked layouts, 64-bit lanes take a 32-bit offset that is either signed or unsigned. A word that fails the fixed-bit checks is rejected.

Operands arrive on a valid/ready input and leave through one output register that holds a valid/ready output. Rules for back-pressure:
- `in_ready` is high when the output register is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, the result is frozen and no new input is taken.
- Latency is one cycle from acceptance and does not depend on operand values.

Top module: `vec_addr_gen`

## Requirements
- R1: A word is legal only when bits [31:24] are 8'h04, bit 21 is 1 and bits [15:12] are 4'b1010.
- R2: Bits [23:22] = 2'b10 select 32-bit lanes, VLEN/32 of them. Each lane is the base lane plus the full 32-bit offset lane, scaled.
- R3: Bits [23:22] = 2'b11 select 64-bit lanes, VLEN/64 of them. Each lane is the base lane plus the full 64-bit offset lane, scaled.
- R4: Bits [23:22] = 2'b00 select 64-bit lanes. The offset is bits [31:0] of the offset lane, sign-extended to 64 bits.
- R5: Bits [23:22] = 2'b01 select 64-bit lanes. The offset is bits [31:0] of the offset lane, zero-extended to 64 bits.
- R6: The extended offset is shifted left by the value of bits [11:10], so it is multiplied by 1, 2, 4 or 8.
- R7: Each lane's sum is truncated to the lane width. No carry passes from one lane into the next.
- R8: A legal word accepted with `in_valid && in_ready` gives `out_valid` = 1, `illegal` = 0 and the new result on the next cycle.
- R9: An accepted illegal word sets `illegal` for exactly one cycle, makes `out_valid` 0 and leaves `result` unchanged.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `result` and `out_valid` hold their values.
- R11: A synchronous active-high reset clears `out_valid`, `illegal` and `result`.
- R12: Bits [20:16] and [9:0] (the register-index fields) have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and word present |
| in_ready | output | 1 | Block can take operands |
| insn | input | 32 | Instruction word |
| base_vec | input | VLEN | Base address vector |
| offs_vec | input | VLEN | Offset vector |
| out_valid | output | 1 | Result register holds an address vector |
| out_ready | input | 1 | Consumer takes the result |
| result | output | VLEN | Address vector |
| illegal | output | 1 | One-cycle pulse on an accepted illegal word |

## Verification
The bench checks all four layouts at all four shift amounts against an independent element-by-element model.

It also drives a set of targeted cases:
- A negative unpacked offset. A design that zero-extended it would add about 2^35 instead of subtracting 8.
- A lane sum that overflows. A design that let the carry cross a lane boundary would corrupt the next lane.
- Words that break each fixed field. A design that accepted them would overwrite the held result.
- A stalled output with new input waiting. A design that did not honour back-pressure would lose the first vector.

// File: rtl/vag_pkg.sv
package vag_pkg;
  // Lane layout, taken straight from instruction bits [23:22]
  typedef enum logic [1:0] {
    LAY_S32EXT = 2'b00,
    LAY_U32EXT = 2'b01,
    LAY_PACK32 = 2'b10,
    LAY_PACK64 = 2'b11
  } lane_layout_e;

  typedef struct packed {
    logic         legal;
    lane_layout_e layout;
    logic [1:0]   shamt;
  } vag_ctrl_t;

  localparam int unsigned SLICE_W = 64;
endpackage

// File: rtl/vag_decode.sv
module vag_decode
  import vag_pkg::*;
(
  input  logic [31:0] insn,
  output vag_ctrl_t   ctrl
);
  logic unused_regfields;
  assign unused_regfields = ^{insn[20:16], insn[9:0]};

  always_comb begin
    ctrl.legal  = (insn[31:24] == 8'h04) && insn[21] && (insn[15:12] == 4'b1010);
    ctrl.layout = lane_layout_e'(insn[23:22]);
    ctrl.shamt  = insn[11:10];
  end
endmodule

// File: rtl/vag_slice.sv
module vag_slice
  import vag_pkg::*;
(
  input  lane_layout_e         layout,
  input  logic [1:0]           shamt,
  input  logic [SLICE_W-1:0]   base,
  input  logic [SLICE_W-1:0]   offs,
  output logic [SLICE_W-1:0]   sum
);
  localparam int unsigned HW = SLICE_W / 2;

  logic [SLICE_W-1:0] wide_off;
  logic [SLICE_W-1:0] wide_sum;
  logic [HW-1:0]      narrow_sum [2];

  always_comb begin
    unique case (layout)
      LAY_S32EXT: wide_off = {{HW{offs[HW-1]}}, offs[HW-1:0]};
      LAY_U32EXT: wide_off = {{HW{1'b0}}, offs[HW-1:0]};
      default:    wide_off = offs;
    endcase
    wide_sum = base + (wide_off << shamt);
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign narrow_sum[h] = base[h*HW +: HW] + (offs[h*HW +: HW] << shamt);
  end

  assign sum = (layout == LAY_PACK32) ? {narrow_sum[1], narrow_sum[0]} : wide_sum;
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
  import vag_pkg::*;
#(
  parameter int unsigned VLEN = 256
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     insn,
  input  logic [VLEN-1:0] base_vec,
  input  logic [VLEN-1:0] offs_vec,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [VLEN-1:0] result,
  output logic            illegal
);
  localparam int unsigned NSLICE = VLEN / SLICE_W;

  vag_ctrl_t       ctrl;
  logic [VLEN-1:0] sum_vec;
  logic            take;

  vag_decode u_dec (.insn(insn), .ctrl(ctrl));

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    vag_slice u_slice (
      .layout (ctrl.layout),
      .shamt  (ctrl.shamt),
      .base   (base_vec[s*SLICE_W +: SLICE_W]),
      .offs   (offs_vec[s*SLICE_W +: SLICE_W]),
      .sum    (sum_vec[s*SLICE_W +: SLICE_W])
    );
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
    end else begin
      illegal <= take && !ctrl.legal;
      if (take) begin
        out_valid <= ctrl.legal;
        if (ctrl.legal) result <= sum_vec;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vec_addr_gen_chk.sv
module vec_addr_gen_chk #(
  parameter int unsigned VLEN = 256
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic [31:0]     insn,
  input logic [63:0]     base_lo,
  input logic [31:0]     offs_lo,
  input logic            out_valid,
  input logic            out_ready,
  input logic [VLEN-1:0] result,
  input logic            illegal
);
  logic take, word_ok;
  logic unused_idx;
  assign unused_idx = ^{insn[20:16], insn[9:0]};
  assign take    = in_valid && in_ready;
  assign word_ok = (insn[31:24] == 8'h04) && insn[21] && (insn[15:12] == 4'b1010);

  // R8
  legal_take_chk: assert property (@(posedge clk) disable iff (rst)
    take && word_ok |=> out_valid && !illegal);

  // R9
  bad_word_chk: assert property (@(posedge clk) disable iff (rst)
    take && !word_ok |=> !out_valid && illegal && $stable(result));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(result));

  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !out_valid && !illegal && (result == '0));

  // R5
  uext_lane0_chk: assert property (@(posedge clk) disable iff (rst)
    take && word_ok && (insn[23:22] == 2'b01) |=>
      result[63:0] == $past(base_lo + ({32'd0, offs_lo} << insn[11:10])));
endmodule

bind vec_addr_gen vec_addr_gen_chk #(.VLEN(VLEN)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .insn(insn),
  .base_lo(base_vec[63:0]), .offs_lo(offs_vec[31:0]), .out_valid(out_valid),
  .out_ready(out_ready), .result(result), .illegal(illegal)
);

// File: tb/vec_addr_gen_bench.sv
`timescale 1ns/1ps
module vec_addr_gen_bench;
  localparam int unsigned VLEN = 256;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [31:0]     insn = '0;
  logic [VLEN-1:0] base_vec = '0;
  logic [VLEN-1:0] offs_vec = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [VLEN-1:0] result;
  logic            illegal;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vec_addr_gen #(.VLEN(VLEN)) u_vec_addr_gen (.*);

  function automatic logic [31:0] mk(input logic [1:0] lay, input logic [1:0] sh,
                                     input logic [4:0] zm, input logic [4:0] zn,
                                     input logic [4:0] zd);
    return {8'h04, lay, 1'b1, zm, 4'b1010, sh, zn, zd};
  endfunction

  function automatic logic [VLEN-1:0] model(input logic [31:0] w,
                                            input logic [VLEN-1:0] b,
                                            input logic [VLEN-1:0] o);
    logic [VLEN-1:0] r = '0;
    int sh = int'(w[11:10]);
    if (w[23:22] == 2'b10) begin
      for (int e = 0; e < VLEN/32; e++) begin
        logic [31:0] t = o[e*32 +: 32] * (32'd1 << sh);
        r[e*32 +: 32] = b[e*32 +: 32] + t;
      end
    end else begin
      for (int e = 0; e < VLEN/64; e++) begin
        logic [63:0] x = o[e*64 +: 64];
        if (w[23:22] == 2'b00) x = {{32{x[31]}}, x[31:0]};
        if (w[23:22] == 2'b01) x = {32'd0, x[31:0]};
        r[e*64 +: 64] = b[e*64 +: 64] + x * (64'd1 << sh);
      end
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // drive one word at negedge, sample at the following negedge
  task automatic issue(input logic [31:0] w, input logic [VLEN-1:0] b,
                       input logic [VLEN-1:0] o);
    insn = w; base_vec = b; offs_vec = o; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(!out_valid && !illegal && in_ready, "R11 flags", {255'd0, out_valid}, '0);
    chk(result == '0, "R11 result", result, '0);
  endtask

  task automatic t_layouts();
    string nm [4] = '{"R4 s32ext", "R5 u32ext", "R2 pack32", "R3 pack64"};
    for (int l = 0; l < 4; l++) begin
      for (int s = 0; s < 4; s++) begin
        logic [31:0] w = mk(2'(l), 2'(s), 5'd1, 5'd2, 5'd3);
        logic [VLEN-1:0] b = rnd_vec();
        logic [VLEN-1:0] o = rnd_vec();
        issue(w, b, o);
        chk(result == model(w, b, o), $sformatf("%s R6 shift %0d", nm[l], s),
            result, model(w, b, o));
        chk(out_valid && !illegal, "R8 valid", {254'd0, out_valid, illegal}, 2'b10);
      end
    end
  endtask

  task automatic t_corner();
    logic [VLEN-1:0] b = '0;
    logic [VLEN-1:0] o = '0;
    logic [VLEN-1:0] e;
    // R7: pack32 lane0 0xFFFFFFF0 + 0x10 wraps to 0, lane1 stays 5
    b[31:0] = 32'hFFFF_FFF0; o[31:0] = 32'h10; b[63:32] = 32'd5;
    issue(mk(2'b10, 2'd0, 5'd0, 5'd0, 5'd0), b, o);
    e = '0; e[63:32] = 32'd5;
    chk(result == e, "R7 pack32 wrap", result, e);
    // R7: pack64 all-ones + 1 wraps to 0, lane1 untouched
    b = '0; o = '0; b[63:0] = '1; o[63:0] = 64'd1; b[127:64] = 64'd9;
    issue(mk(2'b11, 2'd0, 5'd0, 5'd0, 5'd0), b, o);
    e = '0; e[127:64] = 64'd9;
    chk(result == e, "R7 pack64 wrap", result, e);
    // R4: offset -1 shifted by 3 -> base - 8; high offset bits ignored
    b = '0; o = '0; b[63:0] = 64'd1000; o[63:0] = 64'h1234_5678_FFFF_FFFF;
    issue(mk(2'b00, 2'd3, 5'd0, 5'd0, 5'd0), b, o);
    e = '0; e[63:0] = 64'd992;
    chk(result == e, "R4 negative offset", result, e);
    // R5: same offset zero-extended -> 1000 + 0xFFFFFFFF*8
    issue(mk(2'b01, 2'd3, 5'd0, 5'd0, 5'd0), b, o);
    e = '0; e[63:0] = 64'd1000 + 64'h7_FFFF_FFF8;
    chk(result == e, "R5 zero-extended offset", result, e);
  endtask

  task automatic t_fields();
    logic [VLEN-1:0] b = rnd_vec();
    logic [VLEN-1:0] o = rnd_vec();
    logic [VLEN-1:0] first;
    issue(mk(2'b11, 2'd2, 5'd0, 5'd0, 5'd0), b, o);
    first = result;
    issue(mk(2'b11, 2'd2, 5'd31, 5'd17, 5'd9), b, o);
    chk(result == first, "R12 index fields ignored", result, first);
  endtask

  task automatic t_illegal();
    logic [31:0] bad [3];
    logic [VLEN-1:0] held;
    bad[0] = mk(2'b11, 2'd1, 5'd0, 5'd0, 5'd0) ^ 32'h0000_1000; // [15:12]
    bad[1] = mk(2'b11, 2'd1, 5'd0, 5'd0, 5'd0) ^ 32'h0020_0000; // bit 21
    bad[2] = mk(2'b11, 2'd1, 5'd0, 5'd0, 5'd0) ^ 32'h0100_0000; // top byte
    for (int i = 0; i < 3; i++) begin
      issue(mk(2'b10, 2'd1, 5'd0, 5'd0, 5'd0), rnd_vec(), rnd_vec());
      held = result;
      issue(bad[i], rnd_vec(), rnd_vec());
      chk(illegal && !out_valid, $sformatf("R1 R9 reject %0d", i),
          {254'd0, illegal, out_valid}, 2'b10);
      chk(result == held, "R9 result held", result, held);
      @(negedge clk);
      chk(!illegal, "R9 one-cycle pulse", {255'd0, illegal}, '0);
    end
  endtask

  task automatic t_backpressure();
    logic [VLEN-1:0] b1 = rnd_vec(), o1 = rnd_vec(), b2 = rnd_vec(), o2 = rnd_vec();
    logic [31:0] w = mk(2'b01, 2'd2, 5'd0, 5'd0, 5'd0);
    out_ready = 1'b0;
    issue(w, b1, o1);
    insn = w; base_vec = b2; offs_vec = o2; in_valid = 1'b1;
    chk(!in_ready, "R10 in_ready low", {255'd0, in_ready}, '0);
    @(negedge clk); @(negedge clk);
    chk(out_valid && result == model(w, b1, o1), "R10 held under stall",
        result, model(w, b1, o1));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && result == model(w, b2, o2), "R10 R8 second after drain",
        result, model(w, b2, o2));
    @(negedge clk);
    chk(!out_valid, "R8 drained", {255'd0, out_valid}, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_layouts();
    t_corner();
    t_fields();
    t_illegal();
    t_backpressure();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule